// File: doc/BRIEF.md
# Transmit Dominant Timeout Guard

This block sits between the serial transmit input of a single-wire bus transceiver and the control of its low-side bus driver. A low level on the transmit input asks for a dominant bus. The guard passes that request on to the driver control only while the transmit path is enabled. It also keeps the request from holding the bus dominant without limit. The guard counts clock cycles of uninterrupted dominant request. When the count reaches a parameterised limit, the driver control is forced recessive and a timeout flag is raised.

The trip is sticky. Once it has tripped, the transmit input must stay high for a parameterised number of consecutive cycles before the flag drops and the driver can follow the input again. A single high sample is not enough. The dominant limit is meant to be sized so that it matches the 6 ms to 20 ms window at the chosen clock. The release count is meant to cover just over 10 µs.

While the flag is set, the driver stays recessive even if the transmit input is still stuck low. A mode controller can therefore drop the transmit path and move to a low-power state without upsetting the bus.

Top module: `txd_dom_guard`

## Requirements
- R1: After reset, `drv_ctl_n` is 1 (recessive) and `dom_timeout` is 0.
- R2: While `tx_en` is 1, `dom_timeout` is 0 and `txd` is 0, `drv_ctl_n` is 0 (dominant). While `txd` is 1, `drv_ctl_n` is 1.
- R3: While `tx_en` is 0, `drv_ctl_n` is 1 whatever `txd` is.
- R4: If `txd` stays 0 with `tx_en` at 1 for `DOM_LIMIT` consecutive rising edges, `dom_timeout` is 1 after the last of those edges and `drv_ctl_n` is 1. After `DOM_LIMIT-1` such edges, the output is still dominant.
- R5: The dominant counter saturates at `DOM_LIMIT`. It does not wrap, so a stuck-low input keeps the driver recessive indefinitely.
- R6: The dominant counter clears on any edge where `txd` is 1 or `tx_en` is 0. A fresh low period then gets the full `DOM_LIMIT` again.
- R7: Once set, `dom_timeout` clears only after `txd` has been 1 on `REL_LIMIT` consecutive rising edges. Fewer edges, or a run broken by a 0, leave it set.
- R8: `dom_timeout` stays set while `tx_en` is 0. The release run still counts while the path is disabled.
- R9: An active-low `rst_n` clears the flag and both counters, even in the middle of a trip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txd | input | 1 | Transmit data, 0 requests dominant |
| tx_en | input | 1 | Transmit path enabled (normal mode) |
| drv_ctl_n | output | 1 | Driver control, 0 drives the bus dominant |
| dom_timeout | output | 1 | Dominant timeout tripped, held until release |

## Verification
The embedded properties check the following on every cycle:
- The flag rises only after an enabled low input.
- The flag falls only after a high input.
- The dominant counter never passes its limit and holds there while the input stays stuck.
- The release counter stays below its limit.

The exact cycle of the trip and the release needs the bench's timed scenarios. So do the restart after a broken release run, the counter clearing when the path is disabled, and the reset in the middle of a trip.

// File: rtl/txg_pkg.sv
package txg_pkg;
  // Saturating increment: stops at lim.
  function automatic int unsigned sat_next(input int unsigned c, input int unsigned lim);
    return (c >= lim) ? lim : c + 1;
  endfunction

  // True when one more increment lands exactly on lim.
  function automatic logic hits_next(input int unsigned c, input int unsigned lim);
    return (c + 1) == lim;
  endfunction
endpackage

// File: rtl/txg_dom_timer.sv
module txg_dom_timer #(
  parameter int unsigned LIMIT = 600
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic trip
);
  import txg_pkg::*;
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else          cnt_q <= CW'(sat_next(32'(cnt_q), LIMIT));
  end

  assign trip = !clr && hits_next(32'(cnt_q), LIMIT);

  // R5
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt_q) <= LIMIT);
  // R5
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(cnt_q) == LIMIT && !clr) |=> (32'(cnt_q) == LIMIT));
endmodule

// File: rtl/txg_release_timer.sv
module txg_release_timer #(
  parameter int unsigned LIMIT = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic release_now
);
  import txg_pkg::*;
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   hi_q <= '0;
    else if (clr) hi_q <= '0;
    else          hi_q <= CW'(sat_next(32'(hi_q), LIMIT - 1));
  end

  assign release_now = !clr && hits_next(32'(hi_q), LIMIT);

  // R7
  hi_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(hi_q) < LIMIT);
endmodule

// File: rtl/txd_dom_guard.sv
module txd_dom_guard #(
  parameter int unsigned DOM_LIMIT = 600,
  parameter int unsigned REL_LIMIT = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic txd,
  input  logic tx_en,
  output logic drv_ctl_n,
  output logic dom_timeout
);
  logic flag_q;
  logic dom_clr, trip_ev;
  logic rel_clr, rel_ev;

  assign dom_clr = txd || !tx_en;
  assign rel_clr = !txd || !flag_q;

  txg_dom_timer #(.LIMIT(DOM_LIMIT)) u_dom (
    .clk(clk), .rst_n(rst_n), .clr(dom_clr), .trip(trip_ev)
  );

  txg_release_timer #(.LIMIT(REL_LIMIT)) u_rel (
    .clk(clk), .rst_n(rst_n), .clr(rel_clr), .release_now(rel_ev)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (trip_ev) flag_q <= 1'b1;
    else if (rel_ev)  flag_q <= 1'b0;
  end

  assign drv_ctl_n   = !(tx_en && !txd && !flag_q);
  assign dom_timeout = flag_q;

  // R4
  flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(!txd && tx_en));
  // R7
  flag_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> $past(txd));
  // R4
  no_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(trip_ev && rel_ev));
endmodule

// File: tb/tb_txd_dom_guard.sv
module tb_txd_dom_guard;
  localparam int unsigned DOM = 600;
  localparam int unsigned REL = 10;

  logic clk = 0, rst_n = 0, txd = 1, tx_en = 0;
  logic drv_ctl_n, dom_timeout;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  txd_dom_guard #(.DOM_LIMIT(DOM), .REL_LIMIT(REL)) dut (
    .clk(clk), .rst_n(rst_n), .txd(txd), .tx_en(tx_en),
    .drv_ctl_n(drv_ctl_n), .dom_timeout(dom_timeout)
  );

  // {en, txd, edges[15:0], exp_drv_n, exp_flag}
  localparam int NV = 17;
  localparam logic [19:0] VEC [NV] = '{
    {1'b1, 1'b1, 16'd5,       1'b1, 1'b0}, // R2 recessive
    {1'b1, 1'b0, 16'd5,       1'b0, 1'b0}, // R2 dominant
    {1'b1, 1'b0, 16'(DOM-6),  1'b0, 1'b0}, // R4 DOM-1 edges
    {1'b1, 1'b0, 16'd1,       1'b1, 1'b1}, // R4 trip
    {1'b1, 1'b0, 16'd50,      1'b1, 1'b1}, // R5 saturate
    {1'b1, 1'b1, 16'(REL-1),  1'b1, 1'b1}, // R7 short run
    {1'b1, 1'b0, 16'd1,       1'b1, 1'b1}, // R7 broken run
    {1'b1, 1'b1, 16'(REL-1),  1'b1, 1'b1}, // R7 restart
    {1'b1, 1'b1, 16'd1,       1'b1, 1'b0}, // R7 release
    {1'b1, 1'b0, 16'd3,       1'b0, 1'b0}, // R6 fresh low
    {1'b0, 1'b0, 16'd3,       1'b1, 1'b0}, // R3 disabled
    {1'b1, 1'b0, 16'(DOM-1),  1'b0, 1'b0}, // R6 cleared by disable
    {1'b0, 1'b0, 16'd5,       1'b1, 1'b0}, // R3
    {1'b1, 1'b0, 16'(DOM),    1'b1, 1'b1}, // R4 trip again
    {1'b0, 1'b0, 16'd5,       1'b1, 1'b1}, // R8 held while disabled
    {1'b0, 1'b1, 16'(REL),    1'b1, 1'b0}, // R8 release while disabled
    {1'b1, 1'b1, 16'd2,       1'b1, 1'b0}  // R2
  };

  task automatic check(input string req, input logic exp_d, input logic exp_f);
    checks++;
    if (drv_ctl_n !== exp_d || dom_timeout !== exp_f) begin
      fails++;
      $display("FAIL %s: drv_ctl_n=%b dom_timeout=%b expected %b %b",
               req, drv_ctl_n, dom_timeout, exp_d, exp_f);
    end
  endtask

  task automatic step(input logic en, input logic t, input int n);
    tx_en = en; txd = t;
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", 1'b1, 1'b0);
    rst_n = 1;
    @(negedge clk);
    check("R1", 1'b1, 1'b0);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][19], VEC[i][18], int'(VEC[i][17:2]));
      check($sformatf("vector %0d (R2-R8 table)", i), VEC[i][1], VEC[i][0]);
    end

    // R3: txd toggling with path disabled never drives
    step(1'b0, 1'b0, 1); check("R3", 1'b1, 1'b0);
    step(1'b0, 1'b1, 1); check("R3", 1'b1, 1'b0);

    // R9: reset in the middle of a trip
    step(1'b1, 1'b0, DOM);
    check("R4", 1'b1, 1'b1);
    rst_n = 0;
    @(negedge clk);
    check("R9", 1'b0, 1'b0);
    rst_n = 1;
    step(1'b1, 1'b0, DOM - 1);
    check("R9", 1'b0, 1'b0);
    step(1'b1, 1'b0, 1);
    check("R9", 1'b1, 1'b1);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule